// File: doc/BRIEF.md
# Peripheral Clock Gate and Reset Sequencer

This block owns a bank of peripheral clock-stop bits and peripheral reset bits. Each channel maps to one bit of the stop vector and, optionally, to one bit of the reset vector; the two bit positions are set independently by parameters. Software posts per-channel enable or disable requests. These go into a small arrival-order queue, and a single sequencer serves them one at a time.

A disable request only stops the channel's clock. An enable request on a channel without a reset line ungates the clock in one update. On a channel with a reset line, the enable runs a timed bring-up. First the reset bit is asserted. After a short wait the clock is ungated. After a much longer wait the reset bit is released. Both waits are expressed in cycles of the reference clock and derive from the `REF_HZ` parameter. A channel reads as enabled only when its clock runs and its reset bit is clear. The stop bit at index `INV_IDX` has inverted polarity.

Top module: `periph_clk_seq`

## Requirements
- R1: After reset, every stop bit holds its stopped value, which is 1 except at index INV_IDX (default 14), where it is 0. Every reset bit is 1 (asserted). A channel flagged in CRIT_MASK instead starts with its clock running and its reset bit at 0.
- R2: An enable request for a stopped channel that has a reset line sets that reset bit in the pop cycle. It ungates the clock exactly SHORT_CYC cycles later and clears the reset bit exactly LONG_CYC cycles after the ungate. At that last update done_o pulses. The clock and reset bit indices come from CLK_MAP and RST_MAP, which are independent of each other.
- R3: SHORT_CYC = ceil(REF_HZ/10000), which is 100 us, and LONG_CYC = ceil(REF_HZ/100), which is 10 ms. Rounding is always upward.
- R4: An enable request for a channel with no reset line (RST_MAP entry -1) sets its stop bit to the running value in the pop cycle. No reset bit changes.
- R5: ch_en_o[c] is 1 only when channel c's stop bit shows the running value and its reset bit, if it has one, is 0.
- R6: An enable request for a channel that already reads enabled completes with done_o in the pop cycle. Neither vector changes.
- R7: Stop bits are 1 = stopped, except bit INV_IDX, where 1 = running.
- R8: A disable request sets only the channel's stop bit to the stopped value. Its reset bit is left unchanged.
- R9: Requests are accepted when req_valid_i && req_ready_o. At most one sequence runs at a time, and queued requests are served in arrival order, one stop-bit change per cycle at most. req_ready_o is low while the QDEPTH-entry queue is full.
- R10: busy_o is high while a request is queued or a sequence is running, and it drops with the final update. done_o is a one-cycle pulse at each completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_ch_i | input | CH_W | Channel index of the request |
| req_en_i | input | 1 | 1 = enable, 0 = disable |
| req_ready_o | output | 1 | Queue has room |
| clk_stop_o | output | STOP_W | Clock-stop vector |
| rst_o | output | RST_W | Peripheral reset vector, 1 = held in reset |
| ch_en_o | output | N_CH | Per-channel enabled status |
| busy_o | output | 1 | Request queued or sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach is a full queue sitting behind a long bring-up sequence, with requests of different kinds waiting in order. The bench starts an enable on a reset-bearing channel and, on the next two cycles, posts a disable and a re-enable for another channel. With the queue depth set to two this fills the queue. The bench then checks that the two queued requests land on consecutive cycles immediately after the reset release. The reference frequency is chosen so that both waits fall on a fractional cycle count, which forces the round-up to show at the ports.

// File: rtl/periph_clk_seq_pkg.sv
`timescale 1ns/1ps
package periph_clk_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_HOLD_RST,
    SEQ_SETTLE
  } seq_state_e;

  function automatic longint unsigned ceil_div(longint unsigned a, longint unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/seq_req_fifo.sv
`timescale 1ns/1ps
module seq_req_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      end
      if (pop_i) rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && pop_i) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/seq_timer.sv
`timescale 1ns/1ps
module seq_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (!zero_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/seq_ch_status.sv
`timescale 1ns/1ps
module seq_ch_status #(
  parameter int N_CH    = 4,
  parameter int STOP_W  = 16,
  parameter int RST_W   = 8,
  parameter int INV_IDX = 14,
  parameter int CLK_MAP [N_CH] = '{0, 3, 14, 5},
  parameter int RST_MAP [N_CH] = '{6, -1, 2, 1}
) (
  input  logic [STOP_W-1:0] stop_i,
  input  logic [RST_W-1:0]  rst_i,
  output logic [N_CH-1:0]   en_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam int  CI   = CLK_MAP[g];
    localparam logic RUNV = (CLK_MAP[g] == INV_IDX);
    if (RST_MAP[g] >= 0) begin : g_rst
      localparam int RI = RST_MAP[g];
      assign en_o[g] = (stop_i[CI] == RUNV) && !rst_i[RI];
    end else begin : g_nrst
      assign en_o[g] = (stop_i[CI] == RUNV);
    end
  end
endmodule

// File: rtl/periph_clk_seq.sv
`timescale 1ns/1ps
module periph_clk_seq #(
  parameter int N_CH    = 4,
  parameter int STOP_W  = 16,
  parameter int RST_W   = 8,
  parameter int QDEPTH  = 4,
  parameter int INV_IDX = 14,
  parameter longint unsigned REF_HZ = 24_000_000,
  parameter int CLK_MAP [N_CH] = '{0, 3, 14, 5},
  parameter int RST_MAP [N_CH] = '{6, -1, 2, 1},
  parameter logic [N_CH-1:0] CRIT_MASK = 4'b1000,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [CH_W-1:0]   req_ch_i,
  input  logic              req_en_i,
  output logic              req_ready_o,
  output logic [STOP_W-1:0] clk_stop_o,
  output logic [RST_W-1:0]  rst_o,
  output logic [N_CH-1:0]   ch_en_o,
  output logic              busy_o,
  output logic              done_o
);
  import periph_clk_seq_pkg::*;

  localparam int SHORT_CYC = int'(ceil_div(REF_HZ, 64'd10000));
  localparam int LONG_CYC  = int'(ceil_div(REF_HZ, 64'd100));
  localparam int TW  = $clog2(LONG_CYC + 1) + 1;
  localparam int SIW = (STOP_W > 1) ? $clog2(STOP_W) : 1;
  localparam int RIW = (RST_W > 1) ? $clog2(RST_W) : 1;
  localparam int QW  = CH_W + 1;

  function automatic logic [STOP_W-1:0] stop_init();
    logic [STOP_W-1:0] v;
    v = '1;
    if (INV_IDX < STOP_W) v[SIW'(INV_IDX)] = 1'b0;
    for (int i = 0; i < N_CH; i++)
      if (CRIT_MASK[i]) v[SIW'(CLK_MAP[i])] = (CLK_MAP[i] == INV_IDX);
    return v;
  endfunction

  function automatic logic [RST_W-1:0] rst_init();
    logic [RST_W-1:0] v;
    v = '1;
    for (int i = 0; i < N_CH; i++)
      if (CRIT_MASK[i] && RST_MAP[i] >= 0) v[RIW'(RST_MAP[i])] = 1'b0;
    return v;
  endfunction

  localparam logic [STOP_W-1:0] STOP_RST = stop_init();
  localparam logic [RST_W-1:0]  RST_RST  = rst_init();

  seq_state_e        state_q;
  logic [CH_W-1:0]   cur_q;
  logic [STOP_W-1:0] stop_q;
  logic [RST_W-1:0]  rst_q;
  logic              done_q;

  logic [QW-1:0]   q_head;
  logic            q_empty, q_full, q_push, q_pop;
  logic [CH_W-1:0] hd_ch;
  logic            hd_en, hd_ok, start_seq;
  logic [SIW-1:0]  h_clk, c_clk;
  logic [RIW-1:0]  h_rst, c_rst;
  logic            h_has;
  logic            t_load, t_zero;
  logic [TW-1:0]   t_val;

  assign req_ready_o = !q_full;
  assign q_push      = req_valid_i && !q_full;

  seq_req_fifo #(.DEPTH(QDEPTH), .W(QW)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (q_push),
    .data_i ({req_en_i, req_ch_i}),
    .pop_i  (q_pop),
    .data_o (q_head),
    .empty_o(q_empty),
    .full_o (q_full)
  );

  seq_ch_status #(
    .N_CH(N_CH), .STOP_W(STOP_W), .RST_W(RST_W), .INV_IDX(INV_IDX),
    .CLK_MAP(CLK_MAP), .RST_MAP(RST_MAP)
  ) u_status (
    .stop_i(stop_q),
    .rst_i (rst_q),
    .en_o  (ch_en_o)
  );

  assign hd_en = q_head[QW-1];
  assign hd_ch = q_head[CH_W-1:0];
  assign hd_ok = ({1'b0, hd_ch} < (CH_W+1)'(N_CH));

  always_comb begin
    h_clk = '0; h_rst = '0; h_has = 1'b0;
    c_clk = '0; c_rst = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (hd_ch == CH_W'(i)) begin
        h_clk = SIW'(CLK_MAP[i]);
        h_rst = RIW'(RST_MAP[i]);
        h_has = (RST_MAP[i] >= 0);
      end
      if (cur_q == CH_W'(i)) begin
        c_clk = SIW'(CLK_MAP[i]);
        c_rst = RIW'(RST_MAP[i]);
      end
    end
  end

  assign q_pop     = (state_q == SEQ_IDLE) && !q_empty;
  assign start_seq = q_pop && hd_ok && hd_en && !ch_en_o[hd_ch] && h_has;
  assign t_load    = start_seq || ((state_q == SEQ_HOLD_RST) && t_zero);
  assign t_val     = start_seq ? TW'(SHORT_CYC - 1) : TW'(LONG_CYC - 1);

  seq_timer #(.W(TW)) u_timer (
    .clk_i, .rst_ni,
    .load_i    (t_load),
    .load_val_i(t_val),
    .zero_o    (t_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cur_q   <= '0;
      stop_q  <= STOP_RST;
      rst_q   <= RST_RST;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: if (q_pop) begin
          if (start_seq) begin
            rst_q[h_rst] <= 1'b1;
            cur_q        <= hd_ch;
            state_q      <= SEQ_HOLD_RST;
          end else begin
            done_q <= 1'b1;
            if (hd_ok && !hd_en)
              stop_q[h_clk] <= (h_clk != SIW'(INV_IDX));
            else if (hd_ok && !ch_en_o[hd_ch])
              stop_q[h_clk] <= (h_clk == SIW'(INV_IDX));
          end
        end
        SEQ_HOLD_RST: if (t_zero) begin
          stop_q[c_clk] <= (c_clk == SIW'(INV_IDX));
          state_q       <= SEQ_SETTLE;
        end
        SEQ_SETTLE: if (t_zero) begin
          rst_q[c_rst] <= 1'b0;
          done_q       <= 1'b1;
          state_q      <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign clk_stop_o = stop_q;
  assign rst_o      = rst_q;
  assign busy_o     = (state_q != SEQ_IDLE) || !q_empty;
  assign done_o     = done_q;
endmodule

// File: rtl/periph_clk_seq_chk.sv
`timescale 1ns/1ps
module periph_clk_seq_chk #(
  parameter int N_CH    = 4,
  parameter int STOP_W  = 16,
  parameter int RST_W   = 8,
  parameter int INV_IDX = 14,
  parameter int CLK_MAP [N_CH] = '{0, 3, 14, 5},
  parameter int RST_MAP [N_CH] = '{6, -1, 2, 1}
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STOP_W-1:0] clk_stop_o,
  input logic [RST_W-1:0]  rst_o,
  input logic              busy_o,
  input logic              done_o
);
  a_r9_one_stop_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(clk_stop_o ^ $past(clk_stop_o)) <= 1);

  a_r10_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    if (RST_MAP[g] >= 0) begin : g_rst
      localparam int   CI   = CLK_MAP[g];
      localparam int   RI   = RST_MAP[g];
      localparam logic RUNV = (CLK_MAP[g] == INV_IDX);

      a_r2_ungate_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(clk_stop_o[CI]) != RUNV && clk_stop_o[CI] == RUNV) |-> (rst_o[RI] && $past(rst_o[RI])));

      a_r2_release_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_o[RI]) |-> (clk_stop_o[CI] == RUNV));

      a_r8_stop_keeps_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(clk_stop_o[CI]) == RUNV && clk_stop_o[CI] != RUNV) |-> $stable(rst_o[RI]));
    end
  end
endmodule

bind periph_clk_seq periph_clk_seq_chk #(
  .N_CH(N_CH), .STOP_W(STOP_W), .RST_W(RST_W), .INV_IDX(INV_IDX),
  .CLK_MAP(CLK_MAP), .RST_MAP(RST_MAP)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_stop_o(clk_stop_o),
  .rst_o(rst_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/periph_clk_seq_tb_top.sv
`timescale 1ns/1ps
module periph_clk_seq_tb_top;
  localparam longint unsigned HZ = 150_050;
  localparam int SHORT = int'((HZ + 9999) / 10000);  // 16
  localparam int LONG  = int'((HZ + 99) / 100);      // 1501
  localparam int B_CLK [4] = '{0, 3, 14, 5};
  localparam int B_RST [4] = '{6, -1, 2, 1};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_en_i = 1'b0;
  logic [1:0]  req_ch_i = '0;
  logic        req_ready_o, busy_o, done_o;
  logic [15:0] clk_stop_o;
  logic [7:0]  rst_o;
  logic [3:0]  ch_en_o;

  logic [15:0] exp_stop;
  logic [7:0]  exp_rst;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  periph_clk_seq #(.REF_HZ(HZ), .QDEPTH(2)) dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_en();
    logic [3:0] e;
    for (int c = 0; c < 4; c++)
      e[c] = (exp_stop[B_CLK[c]] == (B_CLK[c] == 14)) && !(B_RST[c] >= 0 && exp_rst[B_RST[c]]);
    return e;
  endfunction

  task automatic chk_all(string tag);
    chk({tag, " stop"}, 32'(clk_stop_o), 32'(exp_stop));
    chk({tag, " rst"},  32'(rst_o),      32'(exp_rst));
    chk("R5 status",    32'(ch_en_o),    32'(exp_en()));
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic send(int ch, bit en);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_ch_i = 2'(ch); req_en_i = en;
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
  endtask

  // R2 R3 timed enable on channel c; returns after release
  task automatic seq_enable(int c, string tag);
    send(c, 1'b1);
    tick(1);
    exp_rst[B_RST[c]] = 1'b1;
    chk_all({tag, " pop"});
    chk("R10 busy during", 32'(busy_o), 1);
    tick(SHORT - 1);
    chk_all("R3 before ungate");
    tick(1);
    exp_stop[B_CLK[c]] = (B_CLK[c] == 14);
    chk_all("R2 ungate");
    tick(LONG - 1);
    chk_all("R3 before release");
    tick(1);
    exp_rst[B_RST[c]] = 1'b0;
    chk_all("R2 release");
    chk("R10 done", 32'(done_o), 1);
    chk("R10 busy end", 32'(busy_o), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    exp_stop = 16'hFFFF;
    exp_stop[14] = 1'b0;
    exp_stop[5]  = 1'b0;   // critical channel 3 runs
    exp_rst  = 8'hFF;
    exp_rst[1] = 1'b0;
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    chk_all("R1 reset");
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 ready", 32'(req_ready_o), 1);
    chk("R1 done", 32'(done_o), 0);

    // R6: already enabled critical channel
    send(3, 1'b1);
    tick(1);
    chk_all("R6 no change");
    chk("R6 done", 32'(done_o), 1);

    seq_enable(0, "R2 ch0");
    tick(1);
    chk("R10 done pulse", 32'(done_o), 0);

    // R6 again on a reset-bearing channel
    send(0, 1'b1);
    tick(1);
    chk_all("R6 ch0");
    chk("R6 done ch0", 32'(done_o), 1);

    // R8 disable keeps reset
    send(0, 1'b0);
    tick(1);
    exp_stop[0] = 1'b1;
    chk_all("R8 disable ch0");

    // R4 no-reset channel
    send(1, 1'b1);
    tick(1);
    exp_stop[3] = 1'b0;
    chk_all("R4 ungate ch1");
    chk("R4 done", 32'(done_o), 1);

    // R7 inverted polarity channel
    seq_enable(2, "R7 ch2");
    chk("R7 bit14", 32'(clk_stop_o[14]), 1);
    send(2, 1'b0);
    tick(1);
    exp_stop[14] = 1'b0;
    chk_all("R7 disable ch2");

    // R8 disable critical channel leaves its released reset
    send(3, 1'b0);
    tick(1);
    exp_stop[5] = 1'b1;
    chk_all("R8 disable ch3");

    // R9 queue order and full
    send(0, 1'b1);
    send(1, 1'b0);
    send(1, 1'b1);
    exp_rst[6] = 1'b1;
    chk("R9 ready full", 32'(req_ready_o), 0);
    chk_all("R9 seq started");
    tick(SHORT - 1);
    exp_stop[0] = 1'b0;
    chk_all("R9 ungate");
    tick(LONG - 1);
    chk_all("R9 pre release");
    tick(1);
    exp_rst[6] = 1'b0;
    chk_all("R9 release");
    tick(1);
    exp_stop[3] = 1'b1;
    chk_all("R9 second op");
    chk("R9 ready back", 32'(req_ready_o), 1);
    chk("R10 busy queued", 32'(busy_o), 1);
    tick(1);
    exp_stop[3] = 1'b0;
    chk_all("R9 third op");
    chk("R10 busy idle", 32'(busy_o), 0);
    chk("R10 done last", 32'(done_o), 1);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule